// File: doc/BRIEF.md
# Interrupt Distributor

This block collects interrupt requests from two sources and keeps the state for each interrupt ID. Software requests reach it through a command register. Hardware requests reach it through raw input lines. For every ID it stores an enable bit, a pending bit, an active bit, a priority and a trigger mode. All of this state sits behind a single-cycle 32-bit register port.

The block continuously offers one CPU the most urgent interrupt that is enabled, pending and not yet active. It presents that candidate's ID and priority. The CPU takes the candidate with an acknowledge pulse, which moves the ID from pending to active. An end-of-service pulse carrying the ID later clears the active bit.

IDs 0 to 15 are software interrupts. IDs 16 and up each map to one bit of `irq_in`: line k is ID 16+k. Enable and pending state are never written directly. Software changes them through separate set and clear registers, and a written 1 acts while a written 0 does nothing.

Top module: `idist_top`

## Requirements
- R1: Bit 0 of the word at 0x000 is the global enable and resets to 0. While it is 0, no `irq_in` line can make an ID pending, and `cand_valid` is 0.
- R2: The enable bits are set by writing ones to 0x100 and cleared by writing ones to 0x180. ID n lives in word n/32 at bit n%32. Zero bits have no effect. Reading either address returns the current enable bits. All enable bits reset to 0.
- R3: The pending bits use the same scheme, with set at 0x200 and clear at 0x280. The active bits read at 0x300, and writes to that address change nothing.
- R4: Each ID has one priority byte starting at 0x400, with ID n in word n/4 at bits 8*(n%4)+7 down to 8*(n%4). Bits 2:0 of every byte always read 0, so a written 0xFF reads back as 0xF8. Smaller values are more urgent. All priorities reset to 0.
- R5: Trigger codes start at 0xC00, two bits per ID, with ID n in word n/16 at bits 2*(n%16)+1 down to 2*(n%16). IDs 0 to 15 always read 0b10 and ignore writes. Hardware IDs read 0b01 (level) or 0b11 (rising edge). Only the upper bit is writable, and it resets to 0.
- R6: A level-mode line that is high while the global enable is 1 makes its ID pending by the second rising clock edge. The ID stays pending after the line falls. If the line is still high after a clear, the ID becomes pending again.
- R7: In edge mode, only a 0-to-1 change on the line makes the ID pending. A line held high does not make the ID pending again after a clear.
- R8: A write to 0xF00 carries a filter in bits 25:24, a CPU list in bits 23:16 and an ID in bits 3:0. Filter 0b00 makes the ID pending only when list bit 16 is set. Filter 0b10 always makes it pending. Filters 0b01 and 0b11 change nothing.
- R9: The candidate is the ID that is enabled, pending and not active and has the smallest priority value. On equal priority the lower ID wins. `cand_prio` gives that ID's priority byte.
- R10: `cpu_ack` while `cand_valid` is 1 makes the candidate active and clears its pending bit by the next cycle. `cpu_eoi` clears the active bit of `cpu_eoi_id`.
- R11: Reads return their word one cycle later with `bus_rvalid` high. Misaligned, reserved and unimplemented locations read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq_in | input | NUM_IRQ-16 | Raw hardware request lines |
| cand_valid | output | 1 | Candidate present |
| cand_id | output | $clog2(NUM_IRQ) | Candidate ID |
| cand_prio | output | 8 | Candidate priority |
| cpu_ack | input | 1 | Take the candidate |
| cpu_eoi | input | 1 | End of service |
| cpu_eoi_id | input | $clog2(NUM_IRQ) | ID whose service ended |

## Verification
The assertions assume that `cpu_eoi` only names an ID that is currently active. They also assume that the bus issues no more than one access per cycle. They rely on an acknowledge being gated by `cand_valid`, so an acknowledge with no candidate has no effect. The bench meets these conditions in three ways: it sends end-of-service only for IDs it has acknowledged and recorded, it keeps one bus access per task call, and it holds the hardware lines low during the random rounds so that only software-set pending bits feed the arbitration check.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int SGI_N     = 16;
  localparam int PRIO_KEEP = 5;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_SGI  = 12'hF00;

  // strict comparison: equal values never displace an earlier (lower) ID
  function automatic logic prio_wins(input logic [7:0] cand, input logic [7:0] held);
    return cand < held;
  endfunction

  function automatic logic in_word(input int id, input int per_word, input int word);
    return (id / per_word) == word;
  endfunction

  function automatic logic [7:0] prio_byte(input logic [PRIO_KEEP-1:0] kept);
    return {kept, {(8-PRIO_KEEP){1'b0}}};
  endfunction
endpackage

// File: rtl/idist_sampler.sv
module idist_sampler #(
  parameter int NUM_EXT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] irq_in,
  input  logic               glb_en,
  input  logic [NUM_EXT-1:0] edge_cfg,
  output logic [NUM_EXT-1:0] hw_set
);
  logic [NUM_EXT-1:0] irq_q, irq_qq, rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= '0;
      irq_qq <= '0;
    end else begin
      irq_q  <= irq_in;
      irq_qq <= irq_q;
    end
  end

  assign rise = irq_q & ~irq_qq;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
    assign hw_set[k] = glb_en & (edge_cfg[k] ? rise[k] : irq_q[k]);

    // R7
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set[k] && edge_cfg[k]) |=> !(hw_set[k] && edge_cfg[k]));
  end
endmodule

// File: rtl/idist_regs.sv
module idist_regs
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int NUM_EXT = NUM_IRQ - SGI_N,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [11:0]                 bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic                        bus_rvalid,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_EXT-1:0]          hw_set,
  input  logic                        ack_fire,
  input  logic [ID_W-1:0]             ack_id,
  input  logic                        eoi_fire,
  input  logic [ID_W-1:0]             eoi_id,
  output logic                        glb_en,
  output logic [NUM_IRQ-1:0]          en_q,
  output logic [NUM_IRQ-1:0]          pend_q,
  output logic [NUM_IRQ-1:0]          act_q,
  output logic [NUM_IRQ-1:0][7:0]     prio,
  output logic [NUM_EXT-1:0]          edge_cfg
);
  logic wr, rd, aligned;
  logic hit_ctrl, hit_ens, hit_enc, hit_ps, hit_pc, hit_act, hit_pri, hit_cfg, hit_sgi;
  logic [4:0] bank_w;
  logic [7:0] pri_w;
  logic [5:0] cfg_w;
  logic [NUM_IRQ-1:0] ens_m, enc_m, ps_m, pc_m, sgi_m, ack_m, eoi_m, hw_m, pend_d, act_d;
  logic [NUM_IRQ-1:0][PRIO_KEEP-1:0] prio_q;
  logic [NUM_IRQ-1:0][1:0] cfg_code;
  logic [31:0] rmux;
  logic glb_en_q, sgi_hit;

  assign wr      = bus_valid & bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign aligned = bus_addr[1:0] == 2'b00;
  assign hit_ctrl = bus_addr == A_CTRL;
  assign hit_ens  = aligned & (bus_addr[11:7] == 5'b00010);
  assign hit_enc  = aligned & (bus_addr[11:7] == 5'b00011);
  assign hit_ps   = aligned & (bus_addr[11:7] == 5'b00100);
  assign hit_pc   = aligned & (bus_addr[11:7] == 5'b00101);
  assign hit_act  = aligned & (bus_addr[11:7] == 5'b00110);
  assign hit_pri  = aligned & (bus_addr[11:10] == 2'b01);
  assign hit_cfg  = aligned & (bus_addr[11:8] == 4'hC);
  assign hit_sgi  = bus_addr == A_SGI;
  assign bank_w   = bus_addr[6:2];
  assign pri_w    = bus_addr[9:2];
  assign cfg_w    = bus_addr[7:2];

  // software-interrupt command: filter 00 uses list bit 0, 10 means requester only
  assign sgi_hit = wr & hit_sgi &
                   (((bus_wdata[25:24] == 2'b00) & bus_wdata[16]) | (bus_wdata[25:24] == 2'b10));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    if (i < SGI_N) begin : g_sw
      assign cfg_code[i] = 2'b10;
      assign hw_m[i]     = 1'b0;
      assign sgi_m[i]    = sgi_hit & (bus_wdata[3:0] == 4'(i));
    end else begin : g_hw
      assign cfg_code[i] = {edge_cfg[i-SGI_N], 1'b1};
      assign hw_m[i]     = hw_set[i-SGI_N];
      assign sgi_m[i]    = 1'b0;
    end
    assign ens_m[i] = wr & hit_ens & in_word(i, 32, int'(bank_w)) & bus_wdata[i%32];
    assign enc_m[i] = wr & hit_enc & in_word(i, 32, int'(bank_w)) & bus_wdata[i%32];
    assign ps_m[i]  = wr & hit_ps  & in_word(i, 32, int'(bank_w)) & bus_wdata[i%32];
    assign pc_m[i]  = wr & hit_pc  & in_word(i, 32, int'(bank_w)) & bus_wdata[i%32];
    assign ack_m[i] = ack_fire & (ack_id == ID_W'(i));
    assign eoi_m[i] = eoi_fire & (eoi_id == ID_W'(i));
    assign prio[i]  = prio_byte(prio_q[i]);
  end

  // clears (write or acknowledge) win over any set in the same cycle
  assign pend_d = (pend_q | ps_m | hw_m | sgi_m) & ~pc_m & ~ack_m;
  assign act_d  = (act_q | ack_m) & ~eoi_m;
  assign glb_en = glb_en_q;

  always_comb begin
    rmux = '0;
    if (hit_ctrl) rmux[0] = glb_en_q;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (in_word(i, 32, int'(bank_w))) begin
        if (hit_ens | hit_enc) rmux[i%32] = en_q[i];
        if (hit_ps | hit_pc)   rmux[i%32] = pend_q[i];
        if (hit_act)           rmux[i%32] = act_q[i];
      end
      if (hit_pri && in_word(i, 4, int'(pri_w)))  rmux[8*(i%4) +: 8] = prio[i];
      if (hit_cfg && in_word(i, 16, int'(cfg_w))) rmux[2*(i%16) +: 2] = cfg_code[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en_q   <= 1'b0;
      en_q       <= '0;
      pend_q     <= '0;
      act_q      <= '0;
      prio_q     <= '0;
      edge_cfg   <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (wr && hit_ctrl) glb_en_q <= bus_wdata[0];
      en_q   <= (en_q | ens_m) & ~enc_m;
      pend_q <= pend_d;
      act_q  <= act_d;
      for (int i = 0; i < NUM_IRQ; i++)
        if (wr && hit_pri && in_word(i, 4, int'(pri_w)))
          prio_q[i] <= bus_wdata[8*(i%4)+3 +: PRIO_KEEP];
      for (int j = 0; j < NUM_EXT; j++)
        if (wr && hit_cfg && in_word(j + SGI_N, 16, int'(cfg_w)))
          edge_cfg[j] <= bus_wdata[2*((j+SGI_N)%16)+1];
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
    end
  end

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_m != '0) |=> ((en_q & $past(enc_m)) == '0));
  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_m != '0) |=> (((pend_q | $past(ack_m)) & $past(ps_m)) == $past(ps_m)));
  // R10
  act_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_q & ~$past(act_q)) != '0) |-> $past(ack_fire));
  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_q && !wr) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/idist_arbiter.sv
module idist_arbiter
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic [NUM_IRQ-1:0]      elig,
  input  logic [NUM_IRQ-1:0][7:0] prio,
  output logic                    cand_valid,
  output logic [ID_W-1:0]         cand_id,
  output logic [7:0]              cand_prio
);
  logic found;

  always_comb begin
    found     = 1'b0;
    cand_id   = '0;
    cand_prio = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found || prio_wins(prio[i], cand_prio))) begin
        found     = 1'b1;
        cand_id   = ID_W'(i);
        cand_prio = prio[i];
      end
    end
  end

  assign cand_valid = glb_en & found;

  // R9
  cand_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (elig[cand_id] && (cand_prio == prio[cand_id])));
  // R1
  cand_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> glb_en);
endmodule

// File: rtl/idist_top.sv
module idist_top
  import idist_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int NUM_EXT = NUM_IRQ - SGI_N,
  localparam int ID_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               bus_rvalid,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EXT-1:0] irq_in,
  output logic               cand_valid,
  output logic [ID_W-1:0]    cand_id,
  output logic [7:0]         cand_prio,
  input  logic               cpu_ack,
  input  logic               cpu_eoi,
  input  logic [ID_W-1:0]    cpu_eoi_id
);
  logic glb_en, ack_fire;
  logic [NUM_EXT-1:0] edge_cfg, hw_set;
  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, elig;
  logic [NUM_IRQ-1:0][7:0] prio;

  assign ack_fire = cpu_ack & cand_valid;
  assign elig     = en_q & pend_q & ~act_q;

  idist_sampler #(.NUM_EXT(NUM_EXT)) samp_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .glb_en(glb_en),
    .edge_cfg(edge_cfg), .hw_set(hw_set));

  idist_regs #(.NUM_IRQ(NUM_IRQ)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .hw_set(hw_set), .ack_fire(ack_fire), .ack_id(cand_id),
    .eoi_fire(cpu_eoi), .eoi_id(cpu_eoi_id), .glb_en(glb_en), .en_q(en_q),
    .pend_q(pend_q), .act_q(act_q), .prio(prio), .edge_cfg(edge_cfg));

  idist_arbiter #(.NUM_IRQ(NUM_IRQ)) arb_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .elig(elig), .prio(prio),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio));

  // R10
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (act_q[$past(cand_id)] && !pend_q[$past(cand_id)]));
endmodule

// File: tb/idist_top_tb_top.sv
module idist_top_tb_top;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [N-17:0] irq_in = '0;
  logic cand_valid;
  logic [4:0] cand_id, cpu_eoi_id = 0;
  logic [7:0] cand_prio;
  logic cpu_ack = 0, cpu_eoi = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_en, m_pend, m_act;
  logic [7:0]  m_prio [N];

  always #5 clk = ~clk;

  idist_top #(.NUM_IRQ(N)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1; @(negedge clk); cpu_ack = 0;
  endtask

  task automatic eoi(input int id);
    @(negedge clk); cpu_eoi = 1; cpu_eoi_id = 5'(id); @(negedge clk); cpu_eoi = 0;
  endtask

  // expected candidate: {valid, id, prio} packed into one word
  function automatic logic [31:0] best();
    logic v = 0; int bid = 0; logic [7:0] bp = 8'hFF;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && !m_act[i] && (!v || m_prio[i] < bp)) begin
        v = 1; bid = i; bp = m_prio[i];
      end
    return v ? {15'd0, 1'b1, 3'd0, 5'(bid), bp} : 32'h0;
  endfunction

  function automatic logic [31:0] seen();
    return cand_valid ? {15'd0, 1'b1, 3'd0, cand_id, cand_prio} : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R1 reset cand_valid", {31'd0, cand_valid}, 0);
    rd(12'h000, d); check("R1 reset enable", d, 0);
    rd(12'h100, d); check("R2 reset enable bits", d, 0);
    rd(12'h400, d); check("R4 reset prio", d, 0);
    // R5 trigger readback
    rd(12'hC00, d); check("R5 sw cfg", d, 32'hAAAA_AAAA);
    wr(12'hC00, 32'h0); rd(12'hC00, d); check("R5 sw cfg write ignored", d, 32'hAAAA_AAAA);
    wr(12'hC04, 32'h0000_000C); rd(12'hC04, d); check("R5 hw cfg", d, 32'h5555_555D);
    // R4 priority low bits
    wr(12'h404, 32'hFFFF_FFFF); rd(12'h404, d); check("R4 prio mask", d, 32'hF8F8_F8F8);
    wr(12'h404, 32'h0);
    // R2 set/clear
    wr(12'h100, 32'h0000_00F0); wr(12'h100, 32'h0); wr(12'h180, 32'h0000_0030);
    rd(12'h180, d); check("R2 enable set/clear", d, 32'h0000_00C0);
    wr(12'h180, 32'hFFFF_FFFF);
    // R11 unmapped
    rd(12'h104, d); check("R11 word beyond ids", d, 0);
    wr(12'h900, 32'hFFFF_FFFF); rd(12'h900, d); check("R11 reserved", d, 0);
    rd(12'h101, d); check("R11 misaligned", d, 0);
    // R3 active read-only
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, d); check("R3 active write ignored", d, 0);
    // R1 gated inputs
    irq_in[0] = 1; repeat (3) @(negedge clk);
    rd(12'h200, d); check("R1 input blocked", d, 0);
    irq_in[0] = 0;
    wr(12'h000, 32'h1);
    // R6 level on id16
    irq_in[0] = 1; @(negedge clk); @(negedge clk);
    irq_in[0] = 0;
    rd(12'h200, d); check("R6 level pending", d, 32'h0001_0000);
    irq_in[0] = 1; @(negedge clk);
    wr(12'h280, 32'h0001_0000); @(negedge clk);
    rd(12'h200, d); check("R6 level repends", d, 32'h0001_0000);
    irq_in[0] = 0; @(negedge clk); wr(12'h280, 32'hFFFF_FFFF);
    // R7 edge on id17
    irq_in[1] = 1; repeat (3) @(negedge clk);
    rd(12'h200, d); check("R7 edge pending", d, 32'h0002_0000);
    wr(12'h280, 32'h0002_0000); repeat (3) @(negedge clk);
    rd(12'h200, d); check("R7 held high no repend", d, 0);
    irq_in[1] = 0; wr(12'hC04, 32'h0);
    // R8 software requests
    wr(12'hF00, 32'h0001_0003); wr(12'hF00, 32'h0100_0004);
    wr(12'hF00, 32'h0200_0005); wr(12'hF00, 32'h0300_0006);
    wr(12'hF00, 32'h0002_0007);
    rd(12'h200, d); check("R8 filters", d, 32'h0000_0028);
    wr(12'h280, 32'hFFFF_FFFF);
    // R9 tie: ids 5 and 20 equal priority
    wr(12'h404, 32'h0000_4000); wr(12'h414, 32'h0000_0040);
    wr(12'h100, 32'h0010_0020); wr(12'h200, 32'h0010_0020);
    @(negedge clk);
    check("R9 tie lowest id", seen(), {15'd0, 1'b1, 3'd0, 5'd5, 8'h40});
    ack(); check("R10 next after ack", seen(), {15'd0, 1'b1, 3'd0, 5'd20, 8'h40});
    rd(12'h300, d); check("R10 active set", d, 32'h0000_0020);
    rd(12'h200, d); check("R10 pending cleared", d, 32'h0010_0000);
    eoi(5); rd(12'h300, d); check("R10 eoi clears", d, 0);
    wr(12'h000, 32'h0); @(negedge clk);
    check("R1 disabled no cand", {31'd0, cand_valid}, 0);
    wr(12'h000, 32'h1);
    // random rounds for R9/R10
    for (int it = 0; it < 20; it++) begin
      int taken;
      wr(12'h280, 32'hFFFF_FFFF); wr(12'h180, 32'hFFFF_FFFF);
      m_act = 0;
      for (int w = 0; w < 8; w++) begin
        logic [31:0] r = $urandom;
        if (it % 4 == 0) r = r & 32'h1818_1818;
        wr(12'h400 + 12'(4*w), r);
        for (int b = 0; b < 4; b++) m_prio[4*w+b] = r[8*b +: 8] & 8'hF8;
      end
      m_en = $urandom; m_pend = $urandom | 32'h1;
      wr(12'h100, m_en); wr(12'h200, m_pend);
      @(negedge clk);
      check("R9 random cand", seen(), best());
      if (cand_valid) begin
        taken = int'(cand_id);
        ack();
        m_act[taken] = 1; m_pend[taken] = 0;
        check("R10 random after ack", seen(), best());
        eoi(taken);
        m_act[taken] = 0;
        check("R10 random after eoi", seen(), best());
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule